// File: doc/BRIEF.md
# Serial EEPROM Command and Status Engine

This block is the command layer of a small serial EEPROM that sits on a single-wire bus. Bit timing and acknowledge signalling are handled elsewhere. This engine sees the bus as a stream of bytes from the master. Each byte carries a flag that says whether the master ends the command after it. The engine answers each byte with an accept or reject indication. Read data leaves through a request/response handshake: the bit layer asks for the next byte, and it can mark that request as the final one.

Every command opens with a device address byte and an opcode. The engine owns a write-enable latch, a busy flag, a two-bit protection field, a 16-entry page buffer and a byte array. A write or status write that completes starts a timed write cycle. During that cycle the buffered bytes are committed and the block rejects everything except a status read. Sequential reads run for as long as the master keeps asking, and the read pointer wraps at the end of the array.

Top module: `seeprom_cmd_engine`

## Requirements
- R1: Only the device address byte 0xA0 is accepted. Any other address byte is rejected (ack_ok=0), and every further byte of that command is rejected until a byte with rx_last=1 arrives. Such a command has no effect on any state.
- R2: Opcode 0x96 sets the write-enable latch and opcode 0x91 clears it. The latch reads back at status bit 1.
- R3: Opcode 0x6C takes an address high byte, an address low byte and then data bytes. The page write is committed only if the write-enable latch was set when the final data byte (rx_last=1) arrived. Without the latch, all bytes are still acknowledged, but the array stays unchanged and no write cycle starts.
- R4: A committed write or status write holds status bit 0 (busy) at 1 for WRITE_CYCLES clock cycles. At the end of that cycle the write-enable latch reads 0.
- R5: While busy, an opcode other than 0x05 is rejected, together with the bytes that follow it in that command.
- R6: Opcode 0x05 followed by read requests returns the live status byte on every request. The layout is bit 0 busy, bit 1 write enable, bits 3:2 protection level, and all other bits 0.
- R7: Opcode 0x6E followed by one byte (rx_last=1) copies bits 3:2 of that byte into the protection field. This happens only if the write-enable latch is set, and it runs a write cycle whose new value appears when the cycle ends.
- R8: Opcode 0x03 followed by two address bytes, with rx_last=0 on the low byte, starts a sequential read. Each request returns the next byte. The pointer wraps from the last array byte to 0, and address bits above the array size are ignored.
- R9: In a page write, data byte k goes to the page offset (start offset + k) mod 16 within the 16-byte page of the start address. A later byte that lands on the same offset replaces an earlier one.
- R10: Protection level 0 locks nothing, level 1 locks the top quarter of the array, level 2 the top half and level 3 all of it. A page write whose start address is locked leaves the array untouched, starts no write cycle and keeps the write-enable latch.
- R11: ack_valid pulses exactly one cycle after each rx_valid byte. rd_valid pulses exactly one cycle after each rd_req accepted in a read phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A byte from the master is present this cycle |
| rx_data | input | 8 | Byte from the master |
| rx_last | input | 1 | Master ends the command after this byte |
| ack_valid | output | 1 | Acknowledge result for the previous byte is present |
| ack_ok | output | 1 | 1 accepts the byte, 0 rejects it |
| rd_req | input | 1 | Bit layer asks for the next read byte |
| rd_last | input | 1 | This request is the last of the read phase |
| rd_valid | output | 1 | Read byte is present |
| rd_data | output | 8 | Read byte (array data or status) |

## Verification
A wrong latch or busy flag shows up on the very next status read. It also shows up as a wrong accept/reject on the opcode byte of the next command. Both appear one cycle after the offending byte or request. A wrong page offset, pointer wrap or protection decision stays hidden until the array is read back after the write cycle. The reads are therefore chosen to cover the page edges, the array end and the segment boundaries. The protection field is checked right after each status write completes, and again indirectly by whether the next write lands.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    typedef enum logic [2:0] {
        ST_DEV,
        ST_CMD,
        ST_AHI,
        ST_ALO,
        ST_WDATA,
        ST_SRDATA,
        ST_READ,
        ST_DROP
    } seeprom_st_e;

    localparam logic [7:0] DEV_ADDR = 8'hA0;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h6C;
    localparam logic [7:0] OP_WREN  = 8'h96;
    localparam logic [7:0] OP_WRDI  = 8'h91;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h6E;

    localparam int PAGE_BYTES = 16;

endpackage

// File: rtl/seeprom_prot.sv
module seeprom_prot #(
    parameter int AW = 8
) (
    input  logic [1:0]    level,
    input  logic [AW-1:0] addr,
    output logic          locked
);
    logic [1:0] quarter;
    assign quarter = addr[AW-1:AW-2];

    always_comb begin
        unique case (level)
            2'd0:    locked = 1'b0;
            2'd1:    locked = (quarter == 2'd3);
            2'd2:    locked = quarter[1];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/seeprom_page_buf.sv
module seeprom_page_buf #(
    parameter int PAGE = 16,
    localparam int OW = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [OW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          rd_valid
);
    logic [7:0]      data_d [PAGE];
    logic [7:0]      data_q [PAGE];
    logic [PAGE-1:0] valid_d, valid_q;

    always_comb begin
        valid_d = clear ? '0 : valid_q;
        for (int i = 0; i < PAGE; i++) begin
            data_d[i] = data_q[i];
        end
        if (wr_en) begin
            data_d[wr_idx]  = wr_data;
            valid_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < PAGE; i++) data_q[i] <= '0;
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < PAGE; i++) data_q[i] <= data_d[i];
        end
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
    parameter int BYTES = 256,
    localparam int AW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells_q [BYTES];

    // Erased state is all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) cells_q[i] <= 8'hFF;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/seeprom_cmd_engine.sv
module seeprom_cmd_engine
    import seeprom_pkg::*;
#(
    parameter int MEM_BYTES    = 256,     // power of two, at least 64, below 65536
    parameter int WRITE_CYCLES = 250000   // 5 ms at 50 MHz; must be >= PAGE_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_last,
    output logic       ack_valid,
    output logic       ack_ok,
    input  logic       rd_req,
    input  logic       rd_last,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        seeprom_st_e   st;
        logic [7:0]    op;
        logic [7:0]    addr_hi;
        logic [AW-1:0] ptr;
        logic [OW-1:0] col;
        logic          wel;
        logic          busy;
        logic          is_sr;
        logic [1:0]    bp;
        logic [1:0]    bp_new;
        logic [TW-1:0] elapsed;
        logic          ack_v;
        logic          ack_ok;
        logic          rd_v;
        logic [7:0]    rd_d;
    } eng_t;

    eng_t q, d;

    logic          buf_clear, buf_we;
    logic [OW-1:0] buf_widx;
    logic [7:0]    buf_rdata;
    logic          buf_rvalid;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0]    mem_rdata;
    logic          page_locked;
    logic [7:0]    status;
    logic [15:0]   full_addr;
    logic          unused_addr_hi;

    logic          wip_w, wel_w, at_cmd_w;
    logic [1:0]    bp_w;

    assign status         = {4'b0, q.bp, q.wel, q.busy};
    assign full_addr      = {q.addr_hi, rx_data};
    assign unused_addr_hi = ^full_addr[15:AW];

    seeprom_prot #(.AW(AW)) prot_i (
        .level  (q.bp),
        .addr   (q.ptr),
        .locked (page_locked)
    );

    seeprom_page_buf #(.PAGE(PAGE_BYTES)) pbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (buf_clear),
        .wr_en    (buf_we),
        .wr_idx   (buf_widx),
        .wr_data  (rx_data),
        .rd_idx   (q.elapsed[OW-1:0]),
        .rd_data  (buf_rdata),
        .rd_valid (buf_rvalid)
    );

    seeprom_array #(.BYTES(MEM_BYTES)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_rdata),
        .raddr (q.ptr),
        .rdata (mem_rdata)
    );

    always_comb begin
        d         = q;
        d.ack_v   = 1'b0;
        d.rd_v    = 1'b0;
        buf_clear = 1'b0;
        buf_we    = 1'b0;
        buf_widx  = q.col;
        mem_we    = 1'b0;
        mem_waddr = {q.ptr[AW-1:OW], q.elapsed[OW-1:0]};

        // Write cycle: commit buffered bytes first, then wait out the timer
        if (q.busy) begin
            d.elapsed = q.elapsed + 1'b1;
            if (!q.is_sr && q.elapsed < TW'(PAGE_BYTES) && buf_rvalid) begin
                mem_we = 1'b1;
            end
            if (q.elapsed == TW'(WRITE_CYCLES - 1)) begin
                d.busy = 1'b0;
                d.wel  = 1'b0;
                if (q.is_sr) d.bp = q.bp_new;
            end
        end

        if (rx_valid) begin
            d.ack_v  = 1'b1;
            d.ack_ok = 1'b0;
            unique case (q.st)
                ST_DEV: begin
                    d.ack_ok = (rx_data == DEV_ADDR);
                    d.st     = rx_last ? ST_DEV : ((rx_data == DEV_ADDR) ? ST_CMD : ST_DROP);
                end
                ST_CMD: begin
                    d.op = rx_data;
                    d.st = rx_last ? ST_DEV : ST_DROP;
                    if (!q.busy || rx_data == OP_RDSR) begin
                        unique case (rx_data)
                            OP_WREN: begin
                                d.ack_ok = 1'b1;
                                d.wel    = 1'b1;
                            end
                            OP_WRDI: begin
                                d.ack_ok = 1'b1;
                                d.wel    = 1'b0;
                            end
                            OP_RDSR: begin
                                d.ack_ok = 1'b1;
                                if (!rx_last) d.st = ST_READ;
                            end
                            OP_WRSR: begin
                                d.ack_ok = 1'b1;
                                if (!rx_last) d.st = ST_SRDATA;
                            end
                            OP_READ, OP_WRITE: begin
                                d.ack_ok  = 1'b1;
                                buf_clear = (rx_data == OP_WRITE);
                                if (!rx_last) d.st = ST_AHI;
                            end
                            default: d.ack_ok = 1'b0;
                        endcase
                    end
                end
                ST_AHI: begin
                    d.ack_ok  = 1'b1;
                    d.addr_hi = rx_data;
                    d.st      = rx_last ? ST_DEV : ST_ALO;
                end
                ST_ALO: begin
                    d.ack_ok = 1'b1;
                    d.ptr    = full_addr[AW-1:0];
                    d.col    = rx_data[OW-1:0];
                    if (rx_last)              d.st = ST_DEV;
                    else if (q.op == OP_READ) d.st = ST_READ;
                    else                      d.st = ST_WDATA;
                end
                ST_WDATA: begin
                    d.ack_ok = 1'b1;
                    buf_we   = 1'b1;
                    d.col    = q.col + 1'b1;
                    if (rx_last) begin
                        d.st = ST_DEV;
                        if (q.wel && !page_locked) begin
                            d.busy    = 1'b1;
                            d.is_sr   = 1'b0;
                            d.elapsed = '0;
                        end
                    end
                end
                ST_SRDATA: begin
                    d.ack_ok = rx_last;
                    d.bp_new = rx_data[3:2];
                    d.st     = rx_last ? ST_DEV : ST_DROP;
                    if (rx_last && q.wel) begin
                        d.busy    = 1'b1;
                        d.is_sr   = 1'b1;
                        d.elapsed = '0;
                    end
                end
                default: begin
                    d.st = rx_last ? ST_DEV : ST_DROP;
                end
            endcase
        end else if (rd_req && q.st == ST_READ) begin
            d.rd_v = 1'b1;
            if (q.op == OP_RDSR) begin
                d.rd_d = status;
            end else begin
                d.rd_d = mem_rdata;
                d.ptr  = q.ptr + 1'b1;
            end
            if (rd_last) d.st = ST_DEV;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_DEV;
        end else begin
            q <= d;
        end
    end

    assign ack_valid = q.ack_v;
    assign ack_ok    = q.ack_ok;
    assign rd_valid  = q.rd_v;
    assign rd_data   = q.rd_d;

    assign wip_w    = q.busy;
    assign wel_w    = q.wel;
    assign bp_w     = q.bp;
    assign at_cmd_w = (q.st == ST_CMD);
endmodule

// File: rtl/seeprom_cmd_chk.sv
module seeprom_cmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rd_req,
    input logic       ack_valid,
    input logic       ack_ok,
    input logic       rd_valid,
    input logic       wip,
    input logic       wel,
    input logic [1:0] bp,
    input logic       at_cmd
);
    assert_ack_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(rx_valid));

    assert_rd_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    assert_busy_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && at_cmd && wip && rx_data != 8'h05) |=> (ack_valid && !ack_ok));

    assert_wel_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    assert_wel_set_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(rx_valid && at_cmd && rx_data == 8'h96));

    assert_bp_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wip |=> $stable(bp));
endmodule

bind seeprom_cmd_engine seeprom_cmd_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rd_req    (rd_req),
    .ack_valid (ack_valid),
    .ack_ok    (ack_ok),
    .rd_valid  (rd_valid),
    .wip       (wip_w),
    .wel       (wel_w),
    .bp        (bp_w),
    .at_cmd    (at_cmd_w)
);

// File: tb/seeprom_cmd_engine_tb.sv
module seeprom_cmd_engine_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MEM = 256;
    localparam int WC  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_last = 1'b0, rd_req = 1'b0, rd_last = 1'b0;
    logic [7:0] rx_data = '0;
    logic       ack_valid, ack_ok, rd_valid;
    logic [7:0] rd_data;

    always #10 clk = ~clk;

    seeprom_cmd_engine #(.MEM_BYTES(MEM), .WRITE_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .ack_valid(ack_valid), .ack_ok(ack_ok),
        .rd_req(rd_req), .rd_last(rd_last),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    // Behavioural reference state
    int m_mem[MEM];
    bit m_wel = 0;
    int m_bp = 0;
    bit m_pend = 0, m_psr = 0;
    int m_end = 0, m_pbase = 0, m_pbp = 0;
    int m_pbuf[16];
    bit m_pval[16];
    int wdat[32];

    logic rxv_seen = 0, rdq_seen = 0;
    bit   in_read = 0;

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        rxv_seen <= rst_n && rx_valid;
        rdq_seen <= rst_n && rd_req && in_read;
    end

    // Per-clock handshake comparison (R11)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ack_valid !== rxv_seen) begin
                fails++;
                $display("FAIL R11 ack_valid act=%0b exp=%0b", ack_valid, rxv_seen);
            end
            if (rd_valid !== rdq_seen) begin
                fails++;
                $display("FAIL R11 rd_valid act=%0b exp=%0b", rd_valid, rdq_seen);
            end
        end
    end

    function automatic bit m_busy();
        return m_pend && (cyc < m_end);
    endfunction

    function automatic int m_status();
        return (m_bp << 2) | (int'(m_wel) << 1) | int'(m_busy());
    endfunction

    function automatic bit m_locked(int a);
        int x = a % MEM;
        case (m_bp)
            0: return 0;
            1: return x >= (MEM * 3) / 4;
            2: return x >= MEM / 2;
            default: return 1;
        endcase
    endfunction

    task automatic m_sync();
        if (m_pend && cyc >= m_end) begin
            if (m_psr) m_bp = m_pbp;
            else for (int i = 0; i < 16; i++) if (m_pval[i]) m_mem[m_pbase + i] = m_pbuf[i];
            m_wel  = 0;
            m_pend = 0;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic last, input logic exp_ok, input string req);
        m_sync();
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_last = last;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        check(ack_valid === 1'b1 && ack_ok === exp_ok, req, {ack_valid, ack_ok}, {1'b1, exp_ok});
    endtask

    task automatic rd(input logic last, input int exp, input string req);
        @(negedge clk);
        rd_req = 1'b1; rd_last = last;
        @(negedge clk);
        rd_req = 1'b0; rd_last = 1'b0;
        if (last) in_read = 0;
        check(rd_valid === 1'b1 && rd_data === exp[7:0], req, rd_data, exp);
    endtask

    task automatic wren();
        bit ok;
        m_sync();
        ok = !m_busy();
        send(8'hA0, 0, 1, "R1");
        send(8'h96, 1, ok, "R2");
        if (ok) m_wel = 1;
    endtask

    task automatic wrdi();
        send(8'hA0, 0, 1, "R1");
        send(8'h91, 1, 1, "R2");
        m_wel = 0;
    endtask

    task automatic rdsr(input int n, input string req);
        send(8'hA0, 0, 1, "R1");
        send(8'h05, 0, 1, req);
        in_read = 1;
        for (int i = 0; i < n; i++) begin
            m_sync();
            rd(i == n - 1, m_status(), req);
        end
    endtask

    task automatic do_write(input int a, input int n, input string req);
        send(8'hA0, 0, 1, "R1");
        send(8'h6C, 0, 1, req);
        send(8'((a >> 8) & 255), 0, 1, req);
        send(8'(a & 255), 0, 1, req);
        for (int i = 0; i < n; i++) send(8'(wdat[i]), i == n - 1, 1, req);
        if (m_wel && !m_locked(a)) begin
            for (int i = 0; i < 16; i++) m_pval[i] = 0;
            for (int i = 0; i < n; i++) begin
                m_pbuf[((a % 16) + i) % 16] = wdat[i];
                m_pval[((a % 16) + i) % 16] = 1;
            end
            m_pbase = (a % MEM) & ~15;
            m_psr   = 0;
            m_pend  = 1;
            m_end   = cyc + WC;
        end
    endtask

    task automatic do_wrsr(input int v, input string req);
        send(8'hA0, 0, 1, "R1");
        send(8'h6E, 0, 1, req);
        send(8'(v), 1, 1, req);
        if (m_wel) begin
            m_psr  = 1;
            m_pbp  = (v >> 2) & 3;
            m_pend = 1;
            m_end  = cyc + WC;
        end
    endtask

    task automatic do_read(input int a, input int n, input string req);
        send(8'hA0, 0, 1, "R1");
        send(8'h03, 0, 1, req);
        send(8'((a >> 8) & 255), 0, 1, req);
        send(8'(a & 255), 0, 1, req);
        in_read = 1;
        for (int i = 0; i < n; i++) begin
            m_sync();
            rd(i == n - 1, m_mem[(a + i) % MEM], req);
        end
    endtask

    task automatic settle();
        repeat (WC + 4) @(negedge clk);
        m_sync();
    endtask

    initial begin
        for (int i = 0; i < MEM; i++) m_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack_valid === 1'b0 && rd_valid === 1'b0, "reset R11", {ack_valid, rd_valid}, 0);
        rdsr(2, "R6 reset status");

        // R1: foreign address and the rest of its command rejected
        send(8'hA2, 0, 0, "R1");
        send(8'h96, 1, 0, "R1");
        rdsr(1, "R1 no effect");

        // R3: write without latch leaves array and busy alone
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        do_write(16'h0010, 2, "R3");
        rdsr(1, "R3 no cycle");
        do_read(16'h0010, 2, "R3");

        // R2
        wren(); rdsr(1, "R2 set");
        wrdi(); rdsr(1, "R2 clear");
        wren();

        // R4, R5, R6
        wdat[0] = 8'hA1; wdat[1] = 8'hB2; wdat[2] = 8'hC3;
        do_write(16'h0012, 3, "R3");
        rdsr(3, "R6 busy repeat");
        send(8'hA0, 0, 1, "R1");
        send(8'h03, 0, 0, "R5");
        send(8'h00, 1, 0, "R5");
        wren();
        rdsr(1, "R4 busy");
        settle();
        rdsr(1, "R4 done");
        do_read(16'h0012, 3, "R3");

        // R9: page wrap
        wren();
        for (int i = 0; i < 18; i++) wdat[i] = 8'h40 + i;
        do_write(16'h002E, 18, "R9");
        settle();
        do_read(16'h0020, 16, "R9");

        // R8: pointer wrap and high address bits
        wren();
        wdat[0] = 8'h77;
        do_write(16'h00FF, 1, "R8");
        settle();
        do_read(16'h00FE, 4, "R8");
        do_read(16'h0112, 2, "R8");

        // R7 / R10: protection levels
        do_wrsr(8'h04, "R7");
        rdsr(1, "R7 no latch");
        wren();
        do_wrsr(8'h04, "R7");
        rdsr(1, "R7 busy old bp");
        settle();
        rdsr(1, "R7 applied");
        wren();
        wdat[0] = 8'h99;
        do_write(16'h00C5, 1, "R10");
        rdsr(1, "R10 no cycle");
        do_read(16'h00C5, 1, "R10");
        wdat[0] = 8'h98;
        do_write(16'h0085, 1, "R10");
        settle();
        do_read(16'h0085, 1, "R10");

        wren(); do_wrsr(8'h08, "R7"); settle(); rdsr(1, "R7 half");
        wren();
        wdat[0] = 8'h55;
        do_write(16'h0080, 1, "R10");
        rdsr(1, "R10 half locked");
        wdat[0] = 8'h44;
        do_write(16'h007F, 1, "R10");
        settle();
        do_read(16'h007F, 2, "R10");

        wren(); do_wrsr(8'h0C, "R7"); settle();
        wren();
        wdat[0] = 8'h33;
        do_write(16'h0005, 1, "R10");
        rdsr(1, "R10 all locked");
        do_read(16'h0005, 1, "R10");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule